// File: doc/BRIEF.md
# Data Cache Maintenance Controller

This block executes software-issued maintenance commands against a small direct-mapped, write-back data cache. It owns the per-line tag store. Each entry holds a valid bit, a dirty (W) bit, an address tag and a parity field. The line data itself sits in an external array, which the block reads through an index/data pair. A command carries an instruction word, whose bits 20..18 select the operation, and a virtual address, whose index field selects the cache line.

There are two kinds of operation. Index-based operations act on the selected line whatever it holds. Hit-based operations act only when the stored tag matches the address tag of the command. The create-dirty-exclusive operation claims a line for a new address without fetching it from memory. When an old dirty line has to be saved, the block raises a valid/ready write-back request. The request carries the line's reconstructed block address and the full line data. The line's state is committed only after the memory side accepts the request. Software moves tag entries in and out through two register-side inputs and two register-side outputs.

Top module: `dcm_ctrl`

## Requirements
- R1: The operation is decoded only from instruction bits 20..18. All other instruction bits have no effect. Address bits [3:0] are the byte offset, [6:4] the line index and [31:7] the tag.
- R2: `busy_o` rises on the cycle after a command is accepted, which requires `cmd_valid_i` high while `busy_o` is low. While `busy_o` is high, `cmd_valid_i` is ignored.
- R3: Code 0 acts on the indexed line. If the line is valid and dirty, the block writes it back to the address {stored tag, index, 0}. In all cases the line then becomes invalid, with W cleared.
- R4: Code 1 places the indexed entry on `tag_lo_o`, with bit 0 = valid, bit 1 = W, bits [26:2] = tag and the upper bits zero. It places the stored parity field on `ecc_o`. No parity check is made, and the line is not changed.
- R5: Code 2 writes the indexed entry from the register inputs. Valid comes from `tag_lo_i` bit 0, W from bit 1 and the tag from bits [26:2]. Parity comes from `tag_hi_i` bits [15:0].
- R6: Code 3 first writes the old line back if the line misses and is valid and dirty. The line then always becomes valid and dirty, holding the command's tag, and no fill request is made.
- R7: Code 4 invalidates the line only on a hit. On a miss the line is unchanged.
- R8: Code 5 writes back a hitting dirty line, and on any hit then invalidates the line. On a miss there is no change and no traffic.
- R9: Code 6 writes back a hitting dirty line and then clears W, leaving the line valid. On a miss or a clean hit there is no change and no traffic.
- R10: Code 7 keeps `busy_o` high for exactly one cycle and makes no state change and no write-back.
- R11: `wb_valid_o` stays high, with address and data stable, until `wb_ready_i` is seen. The line update and the fall of `busy_o` follow that handshake.
- R12: After reset all lines are invalid, and `busy_o`, `wb_valid_o`, `tag_lo_o` and `ecc_o` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| cmd_valid_i | input | 1 | Command request |
| cmd_insn_i | input | 32 | Instruction word; bits 20..18 select the operation |
| cmd_addr_i | input | 32 | Virtual address of the command |
| busy_o | output | 1 | A command is in progress |
| tag_lo_i | input | 32 | Register-side tag/state value for code 2 |
| tag_hi_i | input | 32 | Register-side parity value for code 2 |
| tag_lo_o | output | 32 | Tag/state captured by code 1 |
| ecc_o | output | 16 | Parity field captured by code 1 |
| line_idx_o | output | 3 | Index of the line being read from the data array |
| line_data_i | input | 128 | Line data returned for `line_idx_o` |
| wb_valid_o | output | 1 | Write-back request valid |
| wb_ready_i | input | 1 | Memory accepts the write-back |
| wb_addr_o | output | 32 | Block address of the write-back |
| wb_data_o | output | 128 | Line data of the write-back |

## Verification
The bound checker watches the protocol properties on every cycle. It checks that a write-back request holds its address and data until accepted, that no request appears while idle, that an accepted command raises busy on the next cycle, that code 7 clears busy one cycle later, and that the load-tag outputs never move while idle. Which operation writes back what, and what each line holds afterwards, can only be seen through the bench's scenarios. Those scenarios issue each operation on hit, miss, clean, dirty and invalid lines, then read the line back with code 1. The bench also varies memory latency and offers commands while the block is busy.

// File: rtl/dcm_pkg.sv
package dcm_pkg;

    typedef enum logic [2:0] {
        OP_IDX_WBINV    = 3'd0,
        OP_IDX_LDTAG    = 3'd1,
        OP_IDX_STTAG    = 3'd2,
        OP_CREATE_DIRTY = 3'd3,
        OP_HIT_INV      = 3'd4,
        OP_HIT_WBINV    = 3'd5,
        OP_HIT_WB       = 3'd6,
        OP_NOP          = 3'd7
    } maint_op_e;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_LOOKUP = 2'd1,
        ST_WB     = 2'd2
    } fsm_e;

endpackage

// File: rtl/dcm_op_decode.sv
module dcm_op_decode
    import dcm_pkg::*;
#(
    parameter int INSN_W = 32,
    parameter int OP_LSB = 18
) (
    input  logic [INSN_W-1:0] insn_i,
    output maint_op_e         op_o
);
    // R1: only the three operation bits take part in the decode
    assign op_o = maint_op_e'(insn_i[OP_LSB +: 3]);

    logic unused_insn;
    assign unused_insn = ^{insn_i[INSN_W-1:OP_LSB+3], insn_i[OP_LSB-1:0]};
endmodule

// File: rtl/dcm_line_eval.sv
module dcm_line_eval
    import dcm_pkg::*;
#(
    parameter int TAG_W = 25,
    parameter int PAR_W = 16,
    parameter int REG_W = 32
) (
    input  maint_op_e         op_i,
    input  logic              ent_v_i,
    input  logic              ent_w_i,
    input  logic [TAG_W-1:0]  ent_tag_i,
    input  logic [PAR_W-1:0]  ent_par_i,
    input  logic [TAG_W-1:0]  req_tag_i,
    input  logic [REG_W-1:0]  tag_lo_i,
    input  logic [REG_W-1:0]  tag_hi_i,
    output logic              need_wb_o,
    output logic              upd_en_o,
    output logic              load_en_o,
    output logic              nxt_v_o,
    output logic              nxt_w_o,
    output logic [TAG_W-1:0]  nxt_tag_o,
    output logic [PAR_W-1:0]  nxt_par_o
);
    logic hit, dirty;

    assign hit   = ent_v_i && (ent_tag_i == req_tag_i);
    assign dirty = ent_v_i && ent_w_i;

    always_comb begin
        need_wb_o = 1'b0;
        upd_en_o  = 1'b0;
        load_en_o = 1'b0;
        nxt_v_o   = ent_v_i;
        nxt_w_o   = ent_w_i;
        nxt_tag_o = ent_tag_i;
        nxt_par_o = ent_par_i;
        unique case (op_i)
            OP_IDX_WBINV: begin
                need_wb_o = dirty;
                upd_en_o  = 1'b1;
                nxt_v_o   = 1'b0;
                nxt_w_o   = 1'b0;
            end
            OP_IDX_LDTAG: load_en_o = 1'b1;
            OP_IDX_STTAG: begin
                upd_en_o  = 1'b1;
                nxt_v_o   = tag_lo_i[0];
                nxt_w_o   = tag_lo_i[1];
                nxt_tag_o = tag_lo_i[TAG_W+1:2];
                nxt_par_o = tag_hi_i[PAR_W-1:0];
            end
            OP_CREATE_DIRTY: begin
                need_wb_o = !hit && dirty;
                upd_en_o  = 1'b1;
                nxt_v_o   = 1'b1;
                nxt_w_o   = 1'b1;
                nxt_tag_o = req_tag_i;
            end
            OP_HIT_INV: if (hit) begin
                upd_en_o = 1'b1;
                nxt_v_o  = 1'b0;
                nxt_w_o  = 1'b0;
            end
            OP_HIT_WBINV: if (hit) begin
                need_wb_o = ent_w_i;
                upd_en_o  = 1'b1;
                nxt_v_o   = 1'b0;
                nxt_w_o   = 1'b0;
            end
            OP_HIT_WB: if (hit && ent_w_i) begin
                need_wb_o = 1'b1;
                upd_en_o  = 1'b1;
                nxt_w_o   = 1'b0;
            end
            default: ;
        endcase
    end

    logic unused_regs;
    assign unused_regs = ^{tag_lo_i[REG_W-1:TAG_W+2], tag_hi_i[REG_W-1:PAR_W]};
endmodule

// File: rtl/dcm_ctrl.sv
module dcm_ctrl
    import dcm_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int IDX_W  = 3,
    parameter int OFF_W  = 4,
    parameter int LINE_W = 128,
    parameter int REG_W  = 32,
    parameter int INSN_W = 32,
    parameter int OP_LSB = 18
) (
    input  logic                 clk_i,
    input  logic                 rst_ni,
    input  logic                 cmd_valid_i,
    input  logic [INSN_W-1:0]    cmd_insn_i,
    input  logic [ADDR_W-1:0]    cmd_addr_i,
    output logic                 busy_o,
    input  logic [REG_W-1:0]     tag_lo_i,
    input  logic [REG_W-1:0]     tag_hi_i,
    output logic [REG_W-1:0]     tag_lo_o,
    output logic [LINE_W/8-1:0]  ecc_o,
    output logic [IDX_W-1:0]     line_idx_o,
    input  logic [LINE_W-1:0]    line_data_i,
    output logic                 wb_valid_o,
    input  logic                 wb_ready_i,
    output logic [ADDR_W-1:0]    wb_addr_o,
    output logic [LINE_W-1:0]    wb_data_o
);
    localparam int LINES = 1 << IDX_W;
    localparam int TAG_W = ADDR_W - IDX_W - OFF_W;
    localparam int PAR_W = LINE_W / 8;

    typedef struct packed {
        fsm_e                           fsm;
        maint_op_e                      op;
        logic [ADDR_W-1:0]              addr;
        logic [LINES-1:0]               v;
        logic [LINES-1:0]               w;
        logic [LINES-1:0][TAG_W-1:0]    tag;
        logic [LINES-1:0][PAR_W-1:0]    par;
        logic [REG_W-1:0]               tlo;
        logic [PAR_W-1:0]               ecc;
        logic                           wb_valid;
        logic [ADDR_W-1:0]              wb_addr;
    } ctl_t;

    ctl_t q_q, q_d;

    maint_op_e          dec_op;
    logic [IDX_W-1:0]   idx;
    logic [TAG_W-1:0]   req_tag;
    logic               need_wb, upd_en, load_en, nxt_v, nxt_w;
    logic [TAG_W-1:0]   nxt_tag;
    logic [PAR_W-1:0]   nxt_par;

    assign idx     = q_q.addr[OFF_W +: IDX_W];
    assign req_tag = q_q.addr[ADDR_W-1 -: TAG_W];

    dcm_op_decode #(.INSN_W(INSN_W), .OP_LSB(OP_LSB)) dec_i (
        .insn_i (cmd_insn_i),
        .op_o   (dec_op)
    );

    dcm_line_eval #(.TAG_W(TAG_W), .PAR_W(PAR_W), .REG_W(REG_W)) eval_i (
        .op_i      (q_q.op),
        .ent_v_i   (q_q.v[idx]),
        .ent_w_i   (q_q.w[idx]),
        .ent_tag_i (q_q.tag[idx]),
        .ent_par_i (q_q.par[idx]),
        .req_tag_i (req_tag),
        .tag_lo_i  (tag_lo_i),
        .tag_hi_i  (tag_hi_i),
        .need_wb_o (need_wb),
        .upd_en_o  (upd_en),
        .load_en_o (load_en),
        .nxt_v_o   (nxt_v),
        .nxt_w_o   (nxt_w),
        .nxt_tag_o (nxt_tag),
        .nxt_par_o (nxt_par)
    );

    always_comb begin
        logic commit;
        q_d    = q_q;
        commit = 1'b0;
        unique case (q_q.fsm)
            ST_IDLE: if (cmd_valid_i) begin
                q_d.fsm  = ST_LOOKUP;
                q_d.op   = dec_op;
                q_d.addr = cmd_addr_i;
            end
            ST_LOOKUP: begin
                if (need_wb) begin
                    q_d.fsm      = ST_WB;
                    q_d.wb_valid = 1'b1;
                    q_d.wb_addr  = {q_q.tag[idx], idx, {OFF_W{1'b0}}};
                end else begin
                    q_d.fsm = ST_IDLE;
                    commit  = 1'b1;
                end
            end
            ST_WB: if (wb_ready_i) begin
                q_d.fsm      = ST_IDLE;
                q_d.wb_valid = 1'b0;
                commit       = 1'b1;
            end
            default: q_d.fsm = ST_IDLE;
        endcase
        if (commit && upd_en) begin
            q_d.v[idx]   = nxt_v;
            q_d.w[idx]   = nxt_w;
            q_d.tag[idx] = nxt_tag;
            q_d.par[idx] = nxt_par;
        end
        if (commit && load_en) begin
            q_d.tlo = REG_W'({q_q.tag[idx], q_q.w[idx], q_q.v[idx]});
            q_d.ecc = q_q.par[idx];
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) q_q <= '0;
        else         q_q <= q_d;
    end

    assign busy_o     = (q_q.fsm != ST_IDLE);
    assign tag_lo_o   = q_q.tlo;
    assign ecc_o      = q_q.ecc;
    assign line_idx_o = idx;
    assign wb_valid_o = q_q.wb_valid;
    assign wb_addr_o  = q_q.wb_addr;
    assign wb_data_o  = line_data_i;

    logic unused_off;
    assign unused_off = ^q_q.addr[OFF_W-1:0];
endmodule

// File: rtl/dcm_ctrl_chk.sv
module dcm_ctrl_chk #(
    parameter int ADDR_W = 32,
    parameter int LINE_W = 128,
    parameter int REG_W  = 32,
    parameter int INSN_W = 32,
    parameter int OP_LSB = 18
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic              cmd_valid_i,
    input logic [INSN_W-1:0] cmd_insn_i,
    input logic              busy_o,
    input logic [REG_W-1:0]  tag_lo_o,
    input logic              wb_valid_o,
    input logic              wb_ready_i,
    input logic [ADDR_W-1:0] wb_addr_o,
    input logic [LINE_W-1:0] wb_data_o
);
    AST_WB_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wb_valid_o && !wb_ready_i) |=> (wb_valid_o && $stable(wb_addr_o) && $stable(wb_data_o))); // R11

    AST_WB_ONLY_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !busy_o |-> !wb_valid_o); // R11

    AST_ACCEPT_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cmd_valid_i && !busy_o) |=> busy_o); // R2

    AST_NOP_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cmd_valid_i && !busy_o && cmd_insn_i[OP_LSB +: 3] == 3'd7) |=> ##1 !busy_o); // R10

    AST_TAGLO_IDLE_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !busy_o |=> $stable(tag_lo_o)); // R4
endmodule

bind dcm_ctrl dcm_ctrl_chk #(
    .ADDR_W(ADDR_W), .LINE_W(LINE_W), .REG_W(REG_W), .INSN_W(INSN_W), .OP_LSB(OP_LSB)
) chk_i (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cmd_valid_i (cmd_valid_i),
    .cmd_insn_i  (cmd_insn_i),
    .busy_o      (busy_o),
    .tag_lo_o    (tag_lo_o),
    .wb_valid_o  (wb_valid_o),
    .wb_ready_i  (wb_ready_i),
    .wb_addr_o   (wb_addr_o),
    .wb_data_o   (wb_data_o)
);

// File: tb/dcm_ctrl_tb.sv
`timescale 1ns/1ps
module dcm_ctrl_tb_top;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         cmd_valid = 1'b0;
    logic [31:0]  cmd_insn = '0;
    logic [31:0]  cmd_addr = '0;
    logic         busy;
    logic [31:0]  tag_lo_in = '0;
    logic [31:0]  tag_hi_in = '0;
    logic [31:0]  tag_lo_out;
    logic [15:0]  ecc;
    logic [2:0]   line_idx;
    logic [127:0] line_data;
    logic         wb_valid;
    logic         wb_ready = 1'b0;
    logic [31:0]  wb_addr;
    logic [127:0] wb_data;

    int checks = 0;
    int failures = 0;

    localparam logic [31:0] NOISE = 32'hDC03_F2A7 & ~(32'h7 << 18);

    always #4 clk = ~clk;

    // behavioural data array: every byte of line i is {5'b10100, i}
    assign line_data = {16{5'b10100, line_idx}};

    dcm_ctrl dut_i (
        .clk_i(clk), .rst_ni(rst_n), .cmd_valid_i(cmd_valid), .cmd_insn_i(cmd_insn),
        .cmd_addr_i(cmd_addr), .busy_o(busy), .tag_lo_i(tag_lo_in), .tag_hi_i(tag_hi_in),
        .tag_lo_o(tag_lo_out), .ecc_o(ecc), .line_idx_o(line_idx), .line_data_i(line_data),
        .wb_valid_o(wb_valid), .wb_ready_i(wb_ready), .wb_addr_o(wb_addr), .wb_data_o(wb_data)
    );

    typedef struct packed {
        logic [2:0]  op;
        logic [31:0] addr;
        logic [31:0] tl;
        logic        wb;
        logic [31:0] wa;
        logic [31:0] exp_tl;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 23;
    localparam vec_t VECS [NV] = '{
        '{3'd2, 32'h0010, 32'h0047, 1'b0, 32'h0,    32'h0047, 4'd5},  // R5
        '{3'd0, 32'h4C90, 32'h0,    1'b1, 32'h0890, 32'h0044, 4'd3},  // R3 dirty
        '{3'd0, 32'h4C90, 32'h0,    1'b0, 32'h0,    32'h0044, 4'd3},  // R3 invalid
        '{3'd2, 32'h0020, 32'h0089, 1'b0, 32'h0,    32'h0089, 4'd5},
        '{3'd0, 32'h0020, 32'h0,    1'b0, 32'h0,    32'h0088, 4'd3},  // R3 clean
        '{3'd2, 32'h0030, 32'h00CF, 1'b0, 32'h0,    32'h00CF, 4'd5},
        '{3'd3, 32'h2230, 32'h0,    1'b1, 32'h19B0, 32'h0113, 4'd6},  // R6 miss dirty
        '{3'd3, 32'h2238, 32'h0,    1'b0, 32'h0,    32'h0113, 4'd6},  // R6 hit
        '{3'd3, 32'h2AC0, 32'h0,    1'b0, 32'h0,    32'h0157, 4'd6},  // R6 invalid
        '{3'd4, 32'h2B40, 32'h0,    1'b0, 32'h0,    32'h0157, 4'd7},  // R7 miss
        '{3'd4, 32'h2AC4, 32'h0,    1'b0, 32'h0,    32'h0154, 4'd7},  // R7 hit
        '{3'd2, 32'h0050, 32'h019B, 1'b0, 32'h0,    32'h019B, 4'd5},
        '{3'd5, 32'h33D0, 32'h0,    1'b0, 32'h0,    32'h019B, 4'd8},  // R8 miss
        '{3'd5, 32'h3350, 32'h0,    1'b1, 32'h3350, 32'h0198, 4'd8},  // R8 hit dirty
        '{3'd2, 32'h0060, 32'h01DD, 1'b0, 32'h0,    32'h01DD, 4'd5},
        '{3'd5, 32'h3BE0, 32'h0,    1'b0, 32'h0,    32'h01DC, 4'd8},  // R8 hit clean
        '{3'd2, 32'h0070, 32'h003F, 1'b0, 32'h0,    32'h003F, 4'd5},
        '{3'd6, 32'h07F0, 32'h0,    1'b1, 32'h07F0, 32'h003D, 4'd9},  // R9 hit dirty
        '{3'd6, 32'h07F0, 32'h0,    1'b0, 32'h0,    32'h003D, 4'd9},  // R9 hit clean
        '{3'd7, 32'h07F0, 32'h0FFF, 1'b0, 32'h0,    32'h003D, 4'd10}, // R10
        '{3'd0, 32'h0070, 32'h0,    1'b0, 32'h0,    32'h003C, 4'd3},
        '{3'd2, 32'h0070, 32'h003F, 1'b0, 32'h0,    32'h003F, 4'd5},
        '{3'd6, 32'h0870, 32'h0,    1'b0, 32'h0,    32'h003F, 4'd9}   // R9 miss
    };

    task automatic check(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // issues one command (R1: noise in the non-opcode bits); optionally offers a
    // second command while busy
    task automatic run_cmd(input logic [2:0] op, input logic [31:0] addr, input logic [31:0] tl,
                           input logic [31:0] th, input int lat, input bit poke,
                           output int nwb, output logic [31:0] wa, output logic [127:0] wd,
                           output int bcyc);
        int waited;
        @(negedge clk);
        cmd_valid = 1'b1;
        cmd_insn  = NOISE | (32'(op) << 18);
        cmd_addr  = addr;
        tag_lo_in = tl;
        tag_hi_in = th;
        @(negedge clk);
        cmd_valid = 1'b0;
        nwb = 0; wa = '0; wd = '0; bcyc = 0; waited = 0;
        while (busy && bcyc < 1000) begin
            bcyc++;
            if (poke) begin
                cmd_valid = 1'b1;
                cmd_insn  = NOISE | (32'd2 << 18);
                tag_lo_in = 32'h1FF;
            end
            if (wb_valid) begin
                if (waited == 0) begin
                    nwb++;
                    wa = wb_addr;
                    wd = wb_data;
                end
                waited++;
                if (waited >= lat) wb_ready = 1'b1;
            end
            @(negedge clk);
            wb_ready = 1'b0;
        end
        cmd_valid = 1'b0;
    endtask

    initial begin
        #(8 * 200000);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        int nwb, bc;
        logic [31:0] wa;
        logic [127:0] wd, expd;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R12 reset state
        check(busy == 1'b0 && wb_valid == 1'b0, "R12 idle", {busy, wb_valid}, 0);
        check(tag_lo_out == 0 && ecc == 0, "R12 regs", {tag_lo_out, ecc}, 0);
        run_cmd(3'd1, 32'h0030, 0, 0, 1, 0, nwb, wa, wd, bc);
        check(tag_lo_out == 0, "R12 line invalid", tag_lo_out, 0);

        for (int i = 0; i < NV; i++) begin
            run_cmd(VECS[i].op, VECS[i].addr, VECS[i].tl, 0, (i % 3) + 1, 0, nwb, wa, wd, bc);
            check(nwb == int'(VECS[i].wb), $sformatf("R%0d wb count v%0d", VECS[i].req, i), nwb, VECS[i].wb);
            if (VECS[i].wb) begin
                expd = {16{5'b10100, VECS[i].addr[6:4]}};
                check(wa == VECS[i].wa, $sformatf("R%0d wb addr v%0d", VECS[i].req, i), wa, VECS[i].wa);
                check(wd == expd, $sformatf("R11 wb data v%0d", i), wd, expd);
            end
            run_cmd(3'd1, VECS[i].addr, 0, 0, 1, 0, nwb, wa, wd, bc);
            check(tag_lo_out == VECS[i].exp_tl, $sformatf("R%0d R4 line state v%0d", VECS[i].req, i),
                  tag_lo_out, VECS[i].exp_tl);
        end

        // R4 R5 parity field round trip
        run_cmd(3'd2, 32'h0000, 32'h0005, 32'h1234_BEEF, 1, 0, nwb, wa, wd, bc);
        run_cmd(3'd1, 32'h0000, 0, 0, 1, 0, nwb, wa, wd, bc);
        check(ecc == 16'hBEEF, "R4 ecc", ecc, 16'hBEEF);
        check(tag_lo_out == 32'h5, "R5 taglo", tag_lo_out, 32'h5);

        // R10 nop busy one cycle
        run_cmd(3'd7, 32'h0000, 32'h1FF, 0, 1, 0, nwb, wa, wd, bc);
        check(bc == 1 && nwb == 0, "R10 one cycle", bc, 1);

        // R11 R2: slow memory, command offered while busy is ignored
        run_cmd(3'd2, 32'h0040, 32'h00AB, 0, 1, 0, nwb, wa, wd, bc); // tag 0x2A, dirty
        run_cmd(3'd0, 32'h0040, 0, 0, 3, 1, nwb, wa, wd, bc);
        check(bc == 4, "R11 busy until ready", bc, 4);
        check(nwb == 1 && wa == 32'h1540, "R11 wb addr", wa, 32'h1540);
        run_cmd(3'd1, 32'h0040, 0, 0, 1, 0, nwb, wa, wd, bc);
        check(tag_lo_out == 32'h00A8, "R2 ignored while busy", tag_lo_out, 32'h00A8);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule